// File: doc/BRIEF.md
# Processor Stop-Clock Power State Controller

This controller follows the low-power state of a processor core. It has five states: normal execution, auto-halt power-down, stop-grant, stop-clock and stop-clock-snoop. It watches an active-low stop-clock request, a halt indication, the three interrupt lines, the hard and soft reset lines, an external snoop strobe and a flag that says the input clock is stopped or being changed. From these it decides the current state. It asks the bus unit to run a stop-grant cycle or a halt cycle, it pulses a cache-invalidate request during a snoop, and it gates interrupt recognition.

A stop-grant cycle is requested only when the core arrives from normal execution or auto-halt. It is not requested when the core comes back from the stopped-clock states. While the core sits in the stop states, interrupt lines are not recognised. Recognition comes back one clock after the core has fallen back to auto-halt, so a line that is still held then gets serviced. After the input clock restarts, a settling counter of `SETTLE_CYC` cycles must run out before the core may leave stop-clock. The default is 200000 cycles, which is 1 ms at 200 MHz.

Every interface is plain control and status. There is no data stream and no back-pressure.

Top module: `pwr_state_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is normal. The state code is 0 (normal), 1 (auto-halt), 2 (stop-grant), 3 (stop-clock) or 4 (snoop). Both bus-cycle pulses are low, `cache_inv` is low, `irq_en` is 1 and all pending flags are 0.
- R2: In normal with the stop request inactive, `halt_ind` moves the block to auto-halt. `halt_cyc` is high in the first cycle that shows the new state.
- R3: An active stop request (`stop_req_n`=0) in normal or auto-halt moves the block to stop-grant, with `stop_grant_cyc` high in the first stop-grant cycle. This request takes priority over `halt_ind`.
- R4: Auto-halt returns to normal when `hard_rst` or `soft_rst` is high, or when any interrupt line is high while `irq_en` is 1.
- R5: In stop-grant, releasing the stop request moves the block to auto-halt with `halt_cyc` high in the first auto-halt cycle.
- R6: `irq_en` is the state one cycle earlier being normal or auto-halt. While it is 0, the interrupt lines change neither the pending flags nor the state.
- R7: Stop-grant with `clk_stopped` high moves to stop-clock. Once `clk_stopped` falls, the block stays in stop-clock for `SETTLE_CYC` edges and enters stop-grant at edge `SETTLE_CYC`+1, with no `stop_grant_cyc`.
- R8: `snoop_stb` in stop-clock moves the block to snoop for exactly one cycle with `cache_inv` high. The block then returns to stop-clock.
- R9: `pend_o[2]` (INTR) is set when `intr` is sampled with `irq_en` 1, and holds until `intr_ack`.
- R10: `pend_o[1]` (NMI) and `pend_o[0]` (SMI) are set when their line is sampled with `irq_en` 1, and hold until `evt_ack`.
- R11: At most one bus-cycle pulse is high in any cycle, and each pulse lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req_n | input | 1 | Stop-clock request, active low |
| halt_ind | input | 1 | Halt instruction executed |
| intr | input | 1 | Maskable interrupt line |
| nmi | input | 1 | Non-maskable interrupt line |
| smi | input | 1 | System-management interrupt line |
| hard_rst | input | 1 | Hard reset request (wake source) |
| soft_rst | input | 1 | Soft reset request (wake source) |
| snoop_stb | input | 1 | External snoop strobe |
| clk_stopped | input | 1 | Input clock stopped or changing |
| intr_ack | input | 1 | Interrupt acknowledge, clears INTR pending |
| evt_ack | input | 1 | Clears NMI and SMI pending |
| state_o | output | 3 | Current state code |
| stop_grant_cyc | output | 1 | One-cycle stop-grant bus cycle request |
| halt_cyc | output | 1 | One-cycle halt bus cycle request |
| cache_inv | output | 1 | Cache-invalidate pulse in snoop |
| irq_en | output | 1 | Interrupt recognition enable |
| pend_o | output | 3 | Pending flags {INTR, NMI, SMI} |

## Verification
The bench releases the stop request while SMI is held. It expects one more masked cycle in auto-halt before the wake. A design that enables recognition at once would wake a cycle early, and one that latches edges only would never wake. An NMI pulse inside stop-grant must leave no pending flag, and a design that forgets to mask would report it. The settle window is checked on every edge after the clock restarts: leaving a cycle early or late, or raising a stop-grant pulse on the way back, shows up on the exact cycle. Stop requests that arrive together with a halt indication, the one-cycle snoop excursion and a reset in the middle of a state are also covered.

// File: rtl/psc_pkg.sv
package psc_pkg;

  typedef enum logic [2:0] {
    PS_NORMAL    = 3'd0,
    PS_AUTOHALT  = 3'd1,
    PS_STOPGRANT = 3'd2,
    PS_STOPCLK   = 3'd3,
    PS_SNOOP     = 3'd4
  } pstate_e;

  // interrupt line order inside vectors: {intr, nmi, smi}
  localparam int unsigned NLINE    = 3;
  localparam int unsigned LINE_INT = 2;

  function automatic logic is_awake(input pstate_e s);
    return (s == PS_NORMAL) || (s == PS_AUTOHALT);
  endfunction

endpackage

// File: rtl/psc_settle_timer.sv
module psc_settle_timer #(
  parameter int unsigned SETTLE_CYC = 200000
) (
  input  logic clk,
  input  logic rst,
  input  logic clk_stopped,
  output logic ready
);
  localparam int unsigned CW = $clog2(SETTLE_CYC + 2);
  localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYC);

  logic [CW-1:0] cnt_q;

  // reload while the clock is held, count down once it is running again
  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (clk_stopped)
      cnt_q <= LOAD;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign ready = (cnt_q == '0) && !clk_stopped;

endmodule

// File: rtl/psc_irq_gate.sv
module psc_irq_gate
  import psc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  pstate_e          state,
  input  logic [NLINE-1:0] lines,
  input  logic             intr_ack,
  input  logic             evt_ack,
  output logic             irq_en,
  output logic             recog,
  output logic [NLINE-1:0] pend
);
  logic             en_q;
  logic [NLINE-1:0] pend_q;

  // enable follows the previous cycle's state, giving the one-clock lag
  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b1;
    else     en_q <= is_awake(state);
  end

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    logic clr;
    if (g == LINE_INT) begin : g_int
      assign clr = intr_ack;
    end else begin : g_evt
      assign clr = evt_ack;
    end

    always_ff @(posedge clk) begin
      if (rst || clr)
        pend_q[g] <= 1'b0;
      else if (en_q && lines[g])
        pend_q[g] <= 1'b1;
    end
  end

  assign irq_en = en_q;
  assign recog  = en_q && (|lines);
  assign pend   = pend_q;

endmodule

// File: rtl/psc_fsm.sv
module psc_fsm
  import psc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    stop_req_n,
  input  logic    halt_ind,
  input  logic    wake,
  input  logic    snoop_stb,
  input  logic    clk_stopped,
  input  logic    pll_ready,
  output pstate_e state,
  output logic    sg_cyc,
  output logic    halt_cyc,
  output logic    cache_inv
);
  pstate_e state_q, state_d;
  logic    sg_d, halt_d;
  logic    sg_q, halt_q;

  always_comb begin
    state_d = state_q;
    sg_d    = 1'b0;
    halt_d  = 1'b0;
    unique case (state_q)
      PS_NORMAL: begin
        if (!stop_req_n) begin
          state_d = PS_STOPGRANT;
          sg_d    = 1'b1;
        end else if (halt_ind) begin
          state_d = PS_AUTOHALT;
          halt_d  = 1'b1;
        end
      end
      PS_AUTOHALT: begin
        if (!stop_req_n) begin
          state_d = PS_STOPGRANT;
          sg_d    = 1'b1;
        end else if (wake) begin
          state_d = PS_NORMAL;
        end
      end
      PS_STOPGRANT: begin
        if (stop_req_n) begin
          state_d = PS_AUTOHALT;
          halt_d  = 1'b1;
        end else if (clk_stopped) begin
          state_d = PS_STOPCLK;
        end
      end
      PS_STOPCLK: begin
        if (snoop_stb)
          state_d = PS_SNOOP;
        else if (pll_ready)
          state_d = PS_STOPGRANT;
      end
      PS_SNOOP: state_d = PS_STOPCLK;
      default:  state_d = PS_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PS_NORMAL;
      sg_q    <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sg_q    <= sg_d;
      halt_q  <= halt_d;
    end
  end

  assign state     = state_q;
  assign sg_cyc    = sg_q;
  assign halt_cyc  = halt_q;
  assign cache_inv = (state_q == PS_SNOOP);

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import psc_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 200000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       stop_req_n,
  input  logic       halt_ind,
  input  logic       intr,
  input  logic       nmi,
  input  logic       smi,
  input  logic       hard_rst,
  input  logic       soft_rst,
  input  logic       snoop_stb,
  input  logic       clk_stopped,
  input  logic       intr_ack,
  input  logic       evt_ack,
  output logic [2:0] state_o,
  output logic       stop_grant_cyc,
  output logic       halt_cyc,
  output logic       cache_inv,
  output logic       irq_en,
  output logic [2:0] pend_o
);
  pstate_e          cur;
  logic             pll_ready;
  logic             recog;
  logic [NLINE-1:0] pend;

  psc_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .clk_stopped (clk_stopped),
    .ready       (pll_ready)
  );

  psc_irq_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .state    (cur),
    .lines    ({intr, nmi, smi}),
    .intr_ack (intr_ack),
    .evt_ack  (evt_ack),
    .irq_en   (irq_en),
    .recog    (recog),
    .pend     (pend)
  );

  psc_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .stop_req_n  (stop_req_n),
    .halt_ind    (halt_ind),
    .wake        (recog || hard_rst || soft_rst),
    .snoop_stb   (snoop_stb),
    .clk_stopped (clk_stopped),
    .pll_ready   (pll_ready),
    .state       (cur),
    .sg_cyc      (stop_grant_cyc),
    .halt_cyc    (halt_cyc),
    .cache_inv   (cache_inv)
  );

  assign state_o = cur;
  assign pend_o  = pend;

endmodule

// File: rtl/psc_chk.sv
module psc_chk (
  input logic       clk,
  input logic       rst,
  input logic       stop_req_n,
  input logic       clk_stopped,
  input logic       snoop_stb,
  input logic [2:0] state_o,
  input logic       stop_grant_cyc,
  input logic       halt_cyc,
  input logic       cache_inv,
  input logic       irq_en
);
  localparam logic [2:0] C_NRM = 3'd0;
  localparam logic [2:0] C_AH  = 3'd1;
  localparam logic [2:0] C_SG  = 3'd2;
  localparam logic [2:0] C_SC  = 3'd3;
  localparam logic [2:0] C_SN  = 3'd4;

  // R11
  excl_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !(stop_grant_cyc && halt_cyc));

  // R11
  sg_single_chk: assert property (@(posedge clk) disable iff (rst)
    stop_grant_cyc |=> !stop_grant_cyc);

  // R3
  sg_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stop_grant_cyc) |-> (state_o == C_SG) &&
      (($past(state_o) == C_NRM) || ($past(state_o) == C_AH)));

  // R5
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == C_SG && stop_req_n) |=> (state_o == C_AH) && halt_cyc);

  // R7
  sc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == C_SC && clk_stopped && !snoop_stb) |=> (state_o == C_SC));

  // R8
  snoop_ret_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == C_SN) |=> (state_o == C_SC) && !cache_inv);

  // R6
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == C_SC || state_o == C_SN) |-> !irq_en);

endmodule

bind pwr_state_ctrl psc_chk u_psc_chk (
  .clk            (clk),
  .rst            (rst),
  .stop_req_n     (stop_req_n),
  .clk_stopped    (clk_stopped),
  .snoop_stb      (snoop_stb),
  .state_o        (state_o),
  .stop_grant_cyc (stop_grant_cyc),
  .halt_cyc       (halt_cyc),
  .cache_inv      (cache_inv),
  .irq_en         (irq_en)
);

// File: tb/test_pwr_state_ctrl.sv
`timescale 1ns/1ps
module test_pwr_state_ctrl;
  localparam int unsigned SETTLE = 12;
  localparam logic [2:0] NRM = 3'd0, AH = 3'd1, SG = 3'd2, SC = 3'd3, SN = 3'd4;
  localparam logic [9:0] ALL = 10'h3FF;
  localparam logic [9:0] STM = 10'h3F0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_req_n = 1'b1, halt_ind = 1'b0, intr = 1'b0, nmi = 1'b0, smi = 1'b0;
  logic hard_rst = 1'b0, soft_rst = 1'b0, snoop_stb = 1'b0, clk_stopped = 1'b0;
  logic intr_ack = 1'b0, evt_ack = 1'b0;
  logic [2:0] state_o, pend_o;
  logic stop_grant_cyc, halt_cyc, cache_inv, irq_en;

  always #2.5 clk = ~clk;

  pwr_state_ctrl #(.SETTLE_CYC(SETTLE)) i_pwr_state_ctrl (
    .clk(clk), .rst(rst), .stop_req_n(stop_req_n), .halt_ind(halt_ind),
    .intr(intr), .nmi(nmi), .smi(smi), .hard_rst(hard_rst), .soft_rst(soft_rst),
    .snoop_stb(snoop_stb), .clk_stopped(clk_stopped), .intr_ack(intr_ack),
    .evt_ack(evt_ack), .state_o(state_o), .stop_grant_cyc(stop_grant_cyc),
    .halt_cyc(halt_cyc), .cache_inv(cache_inv), .irq_en(irq_en), .pend_o(pend_o)
  );

  typedef struct {
    int         cyc;
    logic [9:0] val;
    logic [9:0] msk;
    string      req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   total = 0;
  int   fails = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [9:0] o(logic [2:0] st, logic sg, logic hl,
                                   logic iv, logic ie, logic [2:0] p);
    return {st, sg, hl, iv, ie, p};
  endfunction

  // driver side: expectation for the state after n more edges
  task automatic expect_at(int n, logic [9:0] v, logic [9:0] m, string r);
    exp_t e;
    e.cyc = cyc + n; e.val = v; e.msk = m; e.req = r;
    q.push_back(e);
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    logic [9:0] obs;
    obs = {state_o, stop_grant_cyc, halt_cyc, cache_inv, irq_en, pend_o};
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (e.cyc != cyc || (obs & e.msk) !== (e.val & e.msk)) begin
        fails++;
        $display("FAIL %s cyc %0d: actual %b expected %b (mask %b)",
                 e.req, cyc, obs, e.val, e.msk);
      end
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst = 1'b0;
    expect_at(0, o(NRM,0,0,0,1,3'b000), ALL, "R1 reset state");
    tick();
    expect_at(0, o(NRM,0,0,0,1,3'b000), ALL, "R1 idle after reset");

    // R2 halt entry
    halt_ind = 1'b1;
    expect_at(1, o(AH,1'b0,1'b1,0,1,3'b000), ALL, "R2 halt entry");
    tick(); halt_ind = 1'b0;
    expect_at(1, o(AH,0,0,0,1,3'b000), ALL, "R11 halt pulse one cycle");
    tick();

    // R4 wake by INTR, R9 pending held until ack
    intr = 1'b1;
    expect_at(1, o(NRM,0,0,0,1,3'b100), ALL, "R4 wake on intr");
    tick(); intr = 1'b0;
    expect_at(1, o(NRM,0,0,0,1,3'b100), ALL, "R9 intr pending held");
    tick(); intr_ack = 1'b1;
    expect_at(1, o(NRM,0,0,0,1,3'b000), ALL, "R9 intr ack clears");
    tick(); intr_ack = 1'b0;

    // R4 wake by soft reset
    halt_ind = 1'b1;
    expect_at(1, o(AH,0,1,0,1,3'b000), ALL, "R2 halt entry again");
    tick(); halt_ind = 1'b0; soft_rst = 1'b1;
    expect_at(1, o(NRM,0,0,0,1,3'b000), ALL, "R4 wake on soft reset");
    tick(); soft_rst = 1'b0;

    // R3 stop from normal beats halt
    stop_req_n = 1'b0; halt_ind = 1'b1;
    expect_at(1, o(SG,1,0,0,1,3'b000), ALL, "R3 stop grant from normal");
    tick(); halt_ind = 1'b0;
    expect_at(1, o(SG,0,0,0,0,3'b000), ALL, "R6 masked in stop grant");
    tick();

    // R6 NMI inside stop grant ignored
    nmi = 1'b1;
    expect_at(1, o(SG,0,0,0,0,3'b000), ALL, "R6 nmi ignored");
    tick(); nmi = 1'b0;
    tick();

    // R5 release with SMI held
    stop_req_n = 1'b1; smi = 1'b1;
    expect_at(1, o(AH,0,1,0,0,3'b000), ALL, "R5 release to auto-halt");
    expect_at(2, o(AH,0,0,0,1,3'b000), ALL, "R6 one clock lag");
    expect_at(3, o(NRM,0,0,0,1,3'b001), ALL, "R4 smi serviced after lag");
    tick(); tick(); tick();
    smi = 1'b0;
    expect_at(1, o(NRM,0,0,0,1,3'b001), ALL, "R10 smi pending held");
    tick(); evt_ack = 1'b1;
    expect_at(1, o(NRM,0,0,0,1,3'b000), ALL, "R10 evt ack clears");
    tick(); evt_ack = 1'b0;

    // R3 stop from auto-halt
    halt_ind = 1'b1;
    tick(); halt_ind = 1'b0; stop_req_n = 1'b0;
    expect_at(1, o(SG,1,0,0,1,3'b000), ALL, "R3 stop grant from auto-halt");
    tick();

    // R7 stop clock entry and hold
    clk_stopped = 1'b1;
    for (int i = 1; i <= 4; i++)
      expect_at(i, o(SC,0,0,0,0,3'b000), ALL, "R7 held while clock stopped");
    tick(); tick(); tick(); tick();

    // R8 snoop excursion
    snoop_stb = 1'b1;
    expect_at(1, o(SN,0,0,1,0,3'b000), ALL, "R8 snoop with invalidate");
    tick(); snoop_stb = 1'b0;
    expect_at(1, o(SC,0,0,0,0,3'b000), ALL, "R8 snoop returns");
    tick();

    // R7 settle window
    clk_stopped = 1'b0;
    for (int i = 1; i <= int'(SETTLE); i++)
      expect_at(i, o(SC,0,0,0,0,3'b000), STM, "R7 settle not done");
    expect_at(int'(SETTLE) + 1, o(SG,0,0,0,0,3'b000), ALL, "R7 exit without stop grant pulse");
    for (int i = 0; i <= int'(SETTLE); i++) tick();

    // back to auto-halt, then hard reset wake
    stop_req_n = 1'b1;
    expect_at(1, o(AH,0,1,0,0,3'b000), ALL, "R5 release after stop clock");
    expect_at(2, o(AH,0,0,0,1,3'b000), ALL, "R6 enable returns");
    tick(); tick();
    hard_rst = 1'b1;
    expect_at(1, o(NRM,0,0,0,1,3'b000), ALL, "R4 wake on hard reset");
    tick(); hard_rst = 1'b0;

    // R1 reset from stop grant
    stop_req_n = 1'b0;
    tick();
    rst = 1'b1; stop_req_n = 1'b1;
    expect_at(1, o(NRM,0,0,0,1,3'b000), ALL, "R1 reset from stop grant");
    tick(); rst = 1'b0;

    tick(); tick();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule